// File: doc/BRIEF.md
# Shadow Stack Instruction Decoder

This combinational block sits in the decode stage of a core. It looks at one 32-bit instruction word and recognises the shadow stack instructions: push of a return address, pop with compare against a link register, read of the shadow stack pointer, and the atomic shadow stack swap in word and doubleword sizes. Three inputs steer the result: a shadow-stack enable, a flag that says the core implements the generic may-be-operation group, and the current XLEN mode.

The push, pop-compare and read-pointer forms are taken out of the generic may-be-operation space in the system opcode region. When shadow stacks are off, those forms fall back to the generic class, or to illegal if the generic group is absent. The swap form has no fallback and becomes illegal. An instruction outside both regions is reported as not handled here, so the main decoder keeps ownership of it.

Top module: `ss_insn_decoder`

## Requirements
- R1: An instruction that is neither in the system region with funct3 100 nor a shadow swap (opcode 0101111, funct5 01001, funct3 010 or 011) gives op_class_o = 0 (none) and illegal_o = 0. Class codes: 0 none, 1 push, 2 pop-check, 3 read-pointer, 4 swap word, 5 swap doubleword, 6 generic may-be-op, 7 illegal.
- R2: With shadow stacks enabled, bits[31:25]=1100111, rs2 in {1,5}, rs1=0, rd=0, funct3=100 and opcode 1110011 decode as push (1).
- R3: With shadow stacks enabled, bits[31:25]=1100110, bits[24:20]=11100, rs1 in {1,5}, rd=0 in the system region decode as pop-check (2).
- R4: With shadow stacks enabled, the same upper bits with rs1=0 and a non-zero rd decode as read-pointer (3).
- R5: Read-pointer with rd=0 is not a shadow operation. It decodes as generic (6) when the generic group is present, and otherwise as illegal (7).
- R6: With shadow stacks disabled, push, pop-check and read-pointer encodings decode as generic (6) when the generic group is present.
- R7: Any other encoding in the generic space decodes as generic (6) when the group is present and as illegal (7) with illegal_o = 1 when it is absent. The generic space is bit31=1 and bits[29:28]=00 in the system region, plus either bits[25:22]=0111 or bit25=1.
- R8: With shadow stacks enabled, the swap decodes as word (4) for funct3 010 and as doubleword (5) for funct3 011 in 64-bit mode.
- R9: With shadow stacks disabled, both swap sizes decode as illegal (7).
- R10: The doubleword swap in 32-bit mode decodes as illegal (7).
- R11: rd_o, rs1_o and rs2_o carry bits[11:7], [19:15] and [24:20]. link_reg_o is the compared or pushed link index (1 or 5) for pop-check and push, and 0 for every other class.
- R12: A near-miss encoding in the generic space decodes as generic (6), not as a shadow operation. Examples are pop-check with rs1=2 and push with rd not equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| ss_en_i | input | 1 | Shadow stacks enabled at the current privilege |
| mop_en_i | input | 1 | Generic may-be-operation group implemented |
| xlen64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| op_class_o | output | 3 | Operation class code |
| rd_o | output | 5 | Destination register field |
| rs1_o | output | 5 | Source 1 register field |
| rs2_o | output | 5 | Source 2 register field |
| link_reg_o | output | 5 | Link register used by push or pop-check, else 0 |
| illegal_o | output | 1 | Illegal instruction |

## Verification
The hardest cases are the ones where a word matches the generic space but misses a shadow form by one field: a wrong link index, a non-zero rd on push, or rd=0 on read-pointer. The stimulus reaches them by building each shadow encoding and then corrupting a single field. Each such word is applied under all relevant settings of the enable and group-present inputs, so the fallback path and the illegal path are both exercised.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  typedef enum logic [2:0] {
    OPC_NONE    = 3'd0,
    OPC_PUSH    = 3'd1,
    OPC_POPCHK  = 3'd2,
    OPC_RDPTR   = 3'd3,
    OPC_SWAP_W  = 3'd4,
    OPC_SWAP_D  = 3'd5,
    OPC_MOP     = 3'd6,
    OPC_ILLEGAL = 3'd7
  } ss_op_e;

  localparam logic [6:0] MAJ_SYSTEM  = 7'b1110011;
  localparam logic [6:0] MAJ_AMO     = 7'b0101111;
  localparam logic [2:0] F3_MOP      = 3'b100;
  localparam logic [2:0] F3_AMO_W    = 3'b010;
  localparam logic [2:0] F3_AMO_D    = 3'b011;
  localparam logic [4:0] F5_SS_SWAP  = 5'b01001;
  localparam logic [6:0] F7_SS_R     = 7'b1100110;
  localparam logic [6:0] F7_SS_RR    = 7'b1100111;
  localparam logic [4:0] SEL_SS_R    = 5'b11100;
endpackage

// File: rtl/ssd_fields.sv
module ssd_fields #(
  parameter int ILEN  = 32,
  parameter int REG_W = 5
) (
  input  logic [ILEN-1:0]  instr_i,
  output logic [6:0]       opcode_o,
  output logic [2:0]       funct3_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] rs1_o,
  output logic [REG_W-1:0] rs2_o,
  output logic [6:0]       funct7_o
);
  localparam int RD_LSB  = 7;
  localparam int F3_LSB  = RD_LSB + REG_W;
  localparam int RS1_LSB = F3_LSB + 3;
  localparam int RS2_LSB = RS1_LSB + REG_W;
  localparam int F7_LSB  = RS2_LSB + REG_W;

  assign opcode_o = instr_i[6:0];
  assign rd_o     = instr_i[RD_LSB +: REG_W];
  assign funct3_o = instr_i[F3_LSB +: 3];
  assign rs1_o    = instr_i[RS1_LSB +: REG_W];
  assign rs2_o    = instr_i[RS2_LSB +: REG_W];
  assign funct7_o = instr_i[F7_LSB +: 7];
endmodule

// File: rtl/ssd_sys_match.sv
module ssd_sys_match
  import ssd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int LINK_A = 1,
  parameter int LINK_B = 5
) (
  input  logic [6:0]       opcode_i,
  input  logic [2:0]       funct3_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic [6:0]       funct7_i,
  output logic             mop_hit_o,
  output logic             push_hit_o,
  output logic             pop_hit_o,
  output logic             rdp_hit_o
);
  localparam int NLINK = 2;
  localparam logic [REG_W-1:0] LINKS [NLINK] = '{REG_W'(LINK_A), REG_W'(LINK_B)};

  logic in_sys;
  logic mop_r, mop_rr;
  logic [NLINK-1:0] rs1_link, rs2_link;

  for (genvar g = 0; g < NLINK; g++) begin : g_link
    assign rs1_link[g] = (rs1_i == LINKS[g]);
    assign rs2_link[g] = (rs2_i == LINKS[g]);
  end

  assign in_sys = (opcode_i == MAJ_SYSTEM) && (funct3_i == F3_MOP);
  // generic space: bit31=1, bits29:28=00; r-form bits25:22=0111, rr-form bit25=1
  assign mop_r  = in_sys && funct7_i[6] && (funct7_i[4:3] == 2'b00) &&
                  !funct7_i[0] && (rs2_i[4:2] == 3'b111);
  assign mop_rr = in_sys && funct7_i[6] && (funct7_i[4:3] == 2'b00) && funct7_i[0];
  assign mop_hit_o = mop_r || mop_rr;

  logic r_hdr;
  assign r_hdr      = in_sys && (funct7_i == F7_SS_R) && (rs2_i == SEL_SS_R);
  assign rdp_hit_o  = r_hdr && (rs1_i == '0) && (rd_i != '0);
  assign pop_hit_o  = r_hdr && (|rs1_link) && (rd_i == '0);
  assign push_hit_o = in_sys && (funct7_i == F7_SS_RR) && (|rs2_link) &&
                      (rs1_i == '0) && (rd_i == '0);

  always_comb begin
    p_excl_r12: assert ($onehot0({push_hit_o, pop_hit_o, rdp_hit_o}))
      else $error("shadow forms overlap");
    if (push_hit_o || pop_hit_o || rdp_hit_o)
      p_carved_r7: assert (mop_hit_o) else $error("shadow form outside generic space");
  end
endmodule

// File: rtl/ssd_amo_match.sv
module ssd_amo_match
  import ssd_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  input  logic [6:0] funct7_i,
  output logic       swap_w_o,
  output logic       swap_d_o
);
  logic hdr;
  assign hdr      = (opcode_i == MAJ_AMO) && (funct7_i[6:2] == F5_SS_SWAP);
  assign swap_w_o = hdr && (funct3_i == F3_AMO_W);
  assign swap_d_o = hdr && (funct3_i == F3_AMO_D);

  always_comb begin
    p_size_excl_r8: assert (!(swap_w_o && swap_d_o)) else $error("both swap sizes");
  end
endmodule

// File: rtl/ss_insn_decoder.sv
module ss_insn_decoder
  import ssd_pkg::*;
#(
  parameter int ILEN  = 32,
  parameter int REG_W = 5
) (
  input  logic [ILEN-1:0]  instr_i,
  input  logic             ss_en_i,
  input  logic             mop_en_i,
  input  logic             xlen64_i,
  output logic [2:0]       op_class_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] rs1_o,
  output logic [REG_W-1:0] rs2_o,
  output logic [REG_W-1:0] link_reg_o,
  output logic             illegal_o
);
  logic [6:0] opcode, funct7;
  logic [2:0] funct3;
  logic mop_hit, push_hit, pop_hit, rdp_hit, swap_w, swap_d;
  ss_op_e op;

  ssd_fields #(.ILEN(ILEN), .REG_W(REG_W)) i_fields (
    .instr_i(instr_i), .opcode_o(opcode), .funct3_o(funct3),
    .rd_o(rd_o), .rs1_o(rs1_o), .rs2_o(rs2_o), .funct7_o(funct7)
  );

  ssd_sys_match #(.REG_W(REG_W)) i_sys (
    .opcode_i(opcode), .funct3_i(funct3), .rd_i(rd_o), .rs1_i(rs1_o),
    .rs2_i(rs2_o), .funct7_i(funct7), .mop_hit_o(mop_hit),
    .push_hit_o(push_hit), .pop_hit_o(pop_hit), .rdp_hit_o(rdp_hit)
  );

  ssd_amo_match i_amo (
    .opcode_i(opcode), .funct3_i(funct3), .funct7_i(funct7),
    .swap_w_o(swap_w), .swap_d_o(swap_d)
  );

  // shadow forms win over generic space only when enabled
  always_comb begin
    op = OPC_NONE;
    if (ss_en_i && push_hit)      op = OPC_PUSH;
    else if (ss_en_i && pop_hit)  op = OPC_POPCHK;
    else if (ss_en_i && rdp_hit)  op = OPC_RDPTR;
    else if (mop_hit)             op = mop_en_i ? OPC_MOP : OPC_ILLEGAL;
    else if (swap_w)              op = ss_en_i ? OPC_SWAP_W : OPC_ILLEGAL;
    else if (swap_d)              op = (ss_en_i && xlen64_i) ? OPC_SWAP_D : OPC_ILLEGAL;
  end

  assign op_class_o = op;
  assign illegal_o  = (op == OPC_ILLEGAL);
  assign link_reg_o = (op == OPC_PUSH)   ? rs2_o :
                      (op == OPC_POPCHK) ? rs1_o : '0;

  always_comb begin
    if (!ss_en_i)
      p_off_no_ss_r6: assert (!(op_class_o inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}))
        else $error("shadow class while disabled");
    if (!ss_en_i && (swap_w || swap_d))
      p_swap_off_r9: assert (illegal_o) else $error("swap legal while disabled");
    if (!xlen64_i)
      p_no_d_rv32_r10: assert (op_class_o != 3'd5) else $error("doubleword swap in 32-bit mode");
    if (op_class_o == 3'd1 || op_class_o == 3'd2)
      p_link_r11: assert (link_reg_o == 5'd1 || link_reg_o == 5'd5) else $error("bad link index");
    if (op_class_o == 3'd3)
      p_rdp_rd_r4: assert (rd_o != '0) else $error("read-pointer with rd=0");
    if (op_class_o != 3'd0)
      p_region_r1: assert (instr_i[6:0] == MAJ_SYSTEM || instr_i[6:0] == MAJ_AMO)
        else $error("claimed foreign opcode");
  end
endmodule

// File: tb/test_ss_insn_decoder.sv
module test_ss_insn_decoder;
  logic        clk = 1'b0;
  logic [31:0] instr_i = '0;
  logic        ss_en_i = 1'b0, mop_en_i = 1'b0, xlen64_i = 1'b0;
  logic [2:0]  op_class_o;
  logic [4:0]  rd_o, rs1_o, rs2_o, link_reg_o;
  logic        illegal_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  localparam logic [2:0] C_NONE = 0, C_PUSH = 1, C_POP = 2, C_RDP = 3,
                         C_SW = 4, C_SD = 5, C_MOP = 6, C_ILL = 7;

  always #5 clk = ~clk;

  ss_insn_decoder i_ss_insn_decoder (
    .instr_i(instr_i), .ss_en_i(ss_en_i), .mop_en_i(mop_en_i), .xlen64_i(xlen64_i),
    .op_class_o(op_class_o), .rd_o(rd_o), .rs1_o(rs1_o), .rs2_o(rs2_o),
    .link_reg_o(link_reg_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc_rdp(input logic [4:0] rd);
    return {7'b1100110, 5'b11100, 5'd0, 3'b100, rd, 7'b1110011};
  endfunction
  function automatic logic [31:0] enc_pop(input logic [4:0] r);
    return {7'b1100110, 5'b11100, r, 3'b100, 5'd0, 7'b1110011};
  endfunction
  function automatic logic [31:0] enc_push(input logic [4:0] r, input logic [4:0] rd);
    return {7'b1100111, r, 5'd0, 3'b100, rd, 7'b1110011};
  endfunction
  function automatic logic [31:0] enc_swap(input logic [2:0] f3);
    return {5'b01001, 2'b00, 5'd3, 5'd2, f3, 5'd4, 7'b0101111};
  endfunction

  task automatic apply(input logic [31:0] w, input logic ss, input logic mop, input logic x64);
    @(negedge clk);
    instr_i = w; ss_en_i = ss; mop_en_i = mop; xlen64_i = x64;
    #2;
  endtask

  task automatic chk(input string tag, input logic [2:0] e_op, input logic [4:0] e_link);
    logic e_ill;
    e_ill = (e_op == C_ILL);
    n_chk++;
    if (op_class_o !== e_op || illegal_o !== e_ill || link_reg_o !== e_link) begin
      n_err++;
      $display("FAIL %s: op=%0d ill=%0b link=%0d expected op=%0d ill=%0b link=%0d",
               tag, op_class_o, illegal_o, link_reg_o, e_op, e_ill, e_link);
    end
  endtask

  task automatic t_idle;
    apply(32'h0, 1, 1, 1); chk("R1 zero word", C_NONE, 0);
  endtask

  task automatic t_not_mine;
    apply(32'h00100093, 1, 1, 1); chk("R1 addi", C_NONE, 0);
    apply({7'b1100110, 5'b11100, 5'd1, 3'b001, 5'd0, 7'b1110011}, 1, 1, 1); chk("R1 csr funct3", C_NONE, 0);
    apply({5'b00001, 2'b00, 5'd3, 5'd2, 3'b010, 5'd4, 7'b0101111}, 1, 1, 1); chk("R1 plain amoswap", C_NONE, 0);
    apply(enc_swap(3'b000), 1, 1, 1); chk("R1 swap byte size", C_NONE, 0);
  endtask

  task automatic t_push;
    apply(enc_push(5'd1, 5'd0), 1, 1, 1); chk("R2 push x1", C_PUSH, 1);
    apply(enc_push(5'd5, 5'd0), 1, 0, 0); chk("R2 push x5 no mop", C_PUSH, 5);
  endtask

  task automatic t_pop;
    apply(enc_pop(5'd1), 1, 1, 0); chk("R3 pop x1", C_POP, 1);
    apply(enc_pop(5'd5), 1, 0, 1); chk("R3 pop x5", C_POP, 5);
  endtask

  task automatic t_rdp;
    apply(enc_rdp(5'd9), 1, 1, 1); chk("R4 rdp rd9", C_RDP, 0);
    if (rd_o !== 5'd9) begin n_err++; $display("FAIL R4 rd=%0d expected 9", rd_o); end
    n_chk++;
  endtask

  task automatic t_rdp_zero;
    apply(enc_rdp(5'd0), 1, 1, 1); chk("R5 rdp rd0 mop", C_MOP, 0);
    apply(enc_rdp(5'd0), 1, 0, 1); chk("R5 rdp rd0 no mop", C_ILL, 0);
  endtask

  task automatic t_ss_off;
    apply(enc_push(5'd1, 5'd0), 0, 1, 1); chk("R6 push off", C_MOP, 0);
    apply(enc_pop(5'd5), 0, 1, 1);        chk("R6 pop off", C_MOP, 0);
    apply(enc_rdp(5'd3), 0, 1, 1);        chk("R6 rdp off", C_MOP, 0);
    apply(enc_pop(5'd1), 0, 0, 1);        chk("R7 pop off no mop", C_ILL, 0);
  endtask

  task automatic t_generic;
    apply({7'b1000000, 5'b11100, 5'd7, 3'b100, 5'd9, 7'b1110011}, 1, 1, 1); chk("R7 mop.r", C_MOP, 0);
    apply({7'b1000001, 5'd3, 5'd4, 3'b100, 5'd6, 7'b1110011}, 1, 1, 1);     chk("R7 mop.rr", C_MOP, 0);
    apply({7'b1000001, 5'd3, 5'd4, 3'b100, 5'd6, 7'b1110011}, 1, 0, 1);     chk("R7 mop.rr absent", C_ILL, 0);
    apply({7'b1010000, 5'b11100, 5'd7, 3'b100, 5'd9, 7'b1110011}, 1, 1, 1); chk("R7 outside space", C_NONE, 0);
  endtask

  task automatic t_swap;
    apply(enc_swap(3'b010), 1, 0, 0); chk("R8 swap.w", C_SW, 0);
    apply(enc_swap(3'b011), 1, 0, 1); chk("R8 swap.d", C_SD, 0);
  endtask

  task automatic t_swap_off;
    apply(enc_swap(3'b010), 0, 1, 1); chk("R9 swap.w off", C_ILL, 0);
    apply(enc_swap(3'b011), 0, 1, 1); chk("R9 swap.d off", C_ILL, 0);
  endtask

  task automatic t_rv32;
    apply(enc_swap(3'b011), 1, 1, 0); chk("R10 swap.d rv32", C_ILL, 0);
  endtask

  task automatic t_fields;
    apply(enc_swap(3'b010), 1, 1, 1);
    n_chk++;
    if (rd_o !== 5'd4 || rs1_o !== 5'd2 || rs2_o !== 5'd3) begin
      n_err++;
      $display("FAIL R11 fields rd=%0d rs1=%0d rs2=%0d expected 4 2 3", rd_o, rs1_o, rs2_o);
    end
  endtask

  task automatic t_near_miss;
    apply(enc_pop(5'd2), 1, 1, 1);         chk("R12 pop rs1=2", C_MOP, 0);
    apply(enc_push(5'd1, 5'd3), 1, 1, 1);  chk("R12 push rd=3", C_MOP, 0);
    apply(enc_push(5'd4, 5'd0), 1, 1, 1);  chk("R12 push rs2=4", C_MOP, 0);
    apply({7'b1100111, 5'd1, 5'd2, 3'b100, 5'd0, 7'b1110011}, 1, 0, 1); chk("R12 push rs1!=0 absent", C_ILL, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_idle;
    t_not_mine;
    t_push;
    t_pop;
    t_rdp;
    t_rdp_zero;
    t_ss_off;
    t_generic;
    t_swap;
    t_swap_off;
    t_rv32;
    t_fields;
    t_near_miss;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule